// File: doc/BRIEF.md
# Variable-Step Sine Oscillator

This block is a numerically controlled oscillator. A phase index register advances by a programmable increment on every rising clock edge. It wraps around a table length that need not be a power of two, so the wrap is a compare-and-subtract on the freshly formed sum rather than a natural binary rollover. The index addresses a sine table that is computed when the design is elaborated. The selected sample is captured in an output register.

The oscillator runs freely. It produces one new index and one new sample on every clock and has no handshake or back-pressure: a downstream consumer samples the outputs when it needs them. Software or a control block sets the output frequency through the increment input. A synchronous reset returns the oscillator to phase zero.

Top module: `nco_sine_top`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a rising edge, the index output becomes 0 and the sample output becomes 0.
- R2: At each rising edge out of reset, the index becomes (index + increment) when that sum is below the table length (default 1000), and (index + increment - table length) otherwise.
- R3: The index output never holds a value at or above the table length.
- R4: The sample output after a rising edge equals the table entry addressed by the index held just before that edge, so the sample trails the index by one clock.
- R5: Table entry k equals round(512 + 512*sin(2*pi*k/1000)) for the default sizes. All entries lie in 0..1024; entries 0 and 500 are 512, entry 250 is 1024 and entry 750 is 0.
- R6: An increment of 0 holds the index, and one clock later the sample, constant.
- R7: An increment equal to the table length returns the index to the same value on every clock.
- R8: An increment above the table length (the input is 10 bits wide, so up to 1023) behaves exactly as an increment equal to the table length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 10 | Phase increment per clock, nominal range 0..1000 |
| addr_o | output | 10 | Current phase index, 0..999 |
| sample_o | output | 11 | Registered sine sample, 0..1024 |

## Verification
The stimulus targets the wrap boundary with increments of 999, 1000 and values above 1000. A design that tests the old index instead of the new sum would then show an index at or above 1000, and an out-of-range sample would follow. Zero increment and full-length increment runs expose a design that drifts when it should hold. The sample is compared one clock behind the index, so a design that reads the table with the updated index, one cycle early, is caught. Quarter-phase entries are checked against exact values, and a reset in the middle of a run must bring the index back to zero.

// File: rtl/nco_sine_pkg.sv
`timescale 1ns/1ps
package nco_sine_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // Rounded, offset sine value for table slot k of len slots; amplitude span 0..2*half.
  function automatic int sine_value(input int k, input int len, input int half);
    real ang;
    real v;
    ang = TWO_PI * real'(k) / real'(len);
    v   = real'(half) + real'(half) * $sin(ang);
    if (v < 0.0) v = 0.0;
    return $rtoi(v + 0.5);
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
  parameter int TBL_LEN = 1000,
  parameter int IDX_W   = $clog2(TBL_LEN),
  parameter int STEP_W  = $clog2(TBL_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int SUM_W = $clog2(2 * TBL_LEN);
  localparam logic [SUM_W-1:0] LEN_S = SUM_W'(TBL_LEN);

  logic [IDX_W-1:0] idx_q;
  logic [SUM_W-1:0] step_eff;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] next_idx;

  // Oversized increments are clamped to one full table turn.
  always_comb begin
    if (SUM_W'(step_i) > LEN_S) step_eff = LEN_S;
    else                        step_eff = SUM_W'(step_i);
    sum = SUM_W'(idx_q) + step_eff;
    // Wrap decision taken on the new sum, never on the old index.
    if (sum >= LEN_S) next_idx = sum - LEN_S;
    else              next_idx = sum;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) idx_q <= '0;
    else       idx_q <= next_idx[IDX_W-1:0];
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/nco_sine_rom.sv
`timescale 1ns/1ps
module nco_sine_rom #(
  parameter int TBL_LEN = 1000,
  parameter int AMP_MAX = 1024,
  parameter int IDX_W   = $clog2(TBL_LEN),
  parameter int SMP_W   = $clog2(AMP_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [SMP_W-1:0] sample_o
);
  localparam int HALF = AMP_MAX / 2;

  logic [SMP_W-1:0] table_w [TBL_LEN];

  // Table contents computed at elaboration, one constant per slot.
  for (genvar k = 0; k < TBL_LEN; k++) begin : g_slot
    localparam int VAL = nco_sine_pkg::sine_value(k, TBL_LEN, HALF);
    assign table_w[k] = SMP_W'(VAL);
  end

  logic [SMP_W-1:0] sample_q;
  always_ff @(posedge clk_i) begin
    if (rst_i)                       sample_q <= '0;
    else if (int'(idx_i) < TBL_LEN)  sample_q <= table_w[idx_i];
    else                             sample_q <= '0;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/nco_sine_top.sv
`timescale 1ns/1ps
module nco_sine_top #(
  parameter int TBL_LEN = 1000,
  parameter int AMP_MAX = 1024,
  parameter int IDX_W   = $clog2(TBL_LEN),
  parameter int STEP_W  = $clog2(TBL_LEN + 1),
  parameter int SMP_W   = $clog2(AMP_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [IDX_W-1:0]  addr_o,
  output logic [SMP_W-1:0]  sample_o
);
  logic [IDX_W-1:0] idx_w;

  nco_phase_acc #(
    .TBL_LEN(TBL_LEN), .IDX_W(IDX_W), .STEP_W(STEP_W)
  ) u_acc (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .step_i(step_i),
    .idx_o (idx_w)
  );

  nco_sine_rom #(
    .TBL_LEN(TBL_LEN), .AMP_MAX(AMP_MAX), .IDX_W(IDX_W), .SMP_W(SMP_W)
  ) u_rom (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .idx_i   (idx_w),
    .sample_o(sample_o)
  );

  assign addr_o = idx_w;
endmodule

// File: rtl/nco_sine_chk.sv
`timescale 1ns/1ps
module nco_sine_chk #(
  parameter int TBL_LEN = 1000,
  parameter int AMP_MAX = 1024,
  parameter int IDX_W   = 10,
  parameter int STEP_W  = 10,
  parameter int SMP_W   = 11
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [STEP_W-1:0] step_i,
  input logic [IDX_W-1:0]  addr_o,
  input logic [SMP_W-1:0]  sample_o
);
  function automatic int ref_next(input int a, input int s);
    int e;
    e = (s > TBL_LEN) ? TBL_LEN : s;
    return (a + e) % TBL_LEN;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (addr_o == '0 && sample_o == '0));

  assert_advance_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> int'(addr_o) == ref_next(int'($past(addr_o)), int'($past(step_i))));

  assert_addr_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(addr_o) < TBL_LEN);

  assert_sample_range_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(sample_o) <= AMP_MAX);

  assert_zero_step_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i == '0) |=> $stable(addr_o));

  assert_full_step_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (int'(step_i) >= TBL_LEN) |=> $stable(addr_o));
endmodule

bind nco_sine_top nco_sine_chk #(
  .TBL_LEN(TBL_LEN), .AMP_MAX(AMP_MAX), .IDX_W(IDX_W), .STEP_W(STEP_W), .SMP_W(SMP_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .step_i  (step_i),
  .addr_o  (addr_o),
  .sample_o(sample_o)
);

// File: tb/nco_sine_top_tb_top.sv
`timescale 1ns/1ps
module nco_sine_top_tb_top;
  localparam int TBL = 1000;
  localparam int HALF = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  step = '0;
  logic [9:0]  addr;
  logic [10:0] sample;

  int errors = 0;
  int checks = 0;
  int m_addr = 0;
  int m_sample = 0;
  bit m_rst = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nco_sine_top dut_i (
    .clk_i(clk), .rst_i(rst), .step_i(step), .addr_o(addr), .sample_o(sample)
  );

  function automatic int ref_sine(input int k);
    real v;
    v = real'(HALF) + real'(HALF) * $sin(6.283185307179586 * real'(k) / real'(TBL));
    if (v < 0.0) v = 0.0;
    return $rtoi(v + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock with given controls; behavioural model advanced, then outputs compared.
  task automatic tick(input bit r, input int s, input string tag);
    int prev;
    int eff;
    prev = m_addr;
    rst  = r;
    step = 10'(s);
    @(posedge clk);
    eff = (s > TBL) ? TBL : s;
    if (r) begin
      m_addr = 0;
      m_sample = 0;
    end else begin
      m_sample = ref_sine(prev);
      m_addr = prev + eff;
      if (m_addr >= TBL) m_addr -= TBL;
    end
    m_rst = r;
    @(negedge clk);
    check(r ? "R1" : tag, int'(addr), m_addr);
    check(r ? "R1" : "R4", int'(sample), m_sample);
    if (!r) begin
      checks++;
      if (int'(addr) >= TBL) begin
        errors++;
        $display("FAIL R3: actual=%0d expected=<%0d", addr, TBL);
      end
      if (prev == 0 || prev == 500) check("R5", int'(sample), 512);
      if (prev == 250) check("R5", int'(sample), 1024);
      if (prev == 750) check("R5", int'(sample), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick(1'b1, 5, "R1");
    for (int i = 0; i < 5; i++) tick(1'b0, 1, "R2");
    tick(1'b1, 0, "R1");
    for (int i = 0; i < 9; i++) tick(1'b0, 250, "R2");
    for (int i = 0; i < 4; i++) tick(1'b0, 0, "R6");
    for (int i = 0; i < 6; i++) tick(1'b0, 999, "R2");
    for (int i = 0; i < 4; i++) tick(1'b0, 1000, "R7");
    for (int i = 0; i < 4; i++) tick(1'b0, 1023, "R8");
    for (int i = 0; i < 4; i++) tick(1'b0, 1001, "R8");
    for (int i = 0; i < 320; i++) tick(1'b0, 7, "R3");
    for (int i = 0; i < 40; i++) tick(1'b0, 333, "R2");
    tick(1'b1, 333, "R1");
    for (int i = 0; i < 6; i++) tick(1'b0, 500, "R2");
    for (int i = 0; i < 3; i++) tick(1'b0, 0, "R6");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule